// File: doc/BRIEF.md
# One-Hot Decimal Ring Accumulator

This block keeps a running decimal total of several digits. Each digit is stored as a ring of ten stages, and exactly one stage is active at a time. Adding to the total does not use a binary or BCD adder. Each digit's ring rotates forward one stage per clock, for as many clocks as that digit of the addend. When a ring passes from nine back to zero, it queues one extra forward step for the next more significant digit. That extra step can itself wrap, so carries ripple upward one digit per clock.

The host places a BCD addend on `addend_i` and pulses `start_i` while `busy_o` is low. It then waits for `busy_o` to fall. The total is read back both as the raw ring stages (`ring_o`) and as BCD (`bcd_o`). A wrap out of the top digit sets a sticky overflow flag. A ring found with other than exactly one active stage is forced back to zero and raises a sticky error flag.

Top module: `dring_accum`

## Requirements
- R1: After a synchronous active-low reset, every digit sits at value 0 (ring stage 0 active), `busy_o`, `ovf_o` and `err_o` are 0.
- R2: Every digit always has exactly one active stage. Bit `10*d+k` of `ring_o` set means digit d holds value k. `bcd_o[4*d+3:4*d]` carries the same value k in BCD. Digit 0 is least significant.
- R3: A start is accepted when `start_i` is high at a rising edge while `busy_o` is low. Digit d of the addend is `addend_i[4*d+3:4*d]`. When `busy_o` falls, the total equals (previous total + addend) modulo 10^NUM_DIGITS.
- R4: A ring moves at most one stage per clock, and only forward (k to k+1, 9 to 0).
- R5: A wrap from 9 to 0 in digit d advances digit d+1 by one extra stage after that digit's own steps. The extra step can wrap again and ripple further.
- R6: Addend digit codes 10 to 15 are treated as 9.
- R7: `busy_o` is high in the cycle after an accepted start. It stays high until all rotations and carries are done, which takes at most 9+NUM_DIGITS+1 clocks.
- R8: A start pulse while `busy_o` is high is ignored and has no effect on the result.
- R9: A wrap out of the most significant digit sets `ovf_o`, which stays set until reset.
- R10: `err_o` is a sticky flag that stays low while all rings are well formed. A ring with zero or several active stages is forced to stage 0 and sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe for one addition |
| addend_i | input | 4*NUM_DIGITS | BCD addend, digit 0 in the low nibble |
| ring_o | output | 10*NUM_DIGITS | One-hot ring state of every digit |
| bcd_o | output | 4*NUM_DIGITS | Total in BCD |
| busy_o | output | 1 | Addition in progress |
| ovf_o | output | 1 | Sticky overflow out of the top digit |
| err_o | output | 1 | Sticky illegal-ring flag |

## Verification
The bench targets the following corner cases:
- **Long carry ripples**, such as 0999 + 1 and 9999 + 1. A design that dropped or merged a queued carry would leave a stale 9 in the total.
- **Zero addend.** It must still produce a short busy pulse. A design with broken completion logic would hang busy or never assert it.
- **Addend nibbles above nine.** A design that added them raw would rotate more than nine stages.
- **A second start during a long operation.** A design that accepted it would reload the step counters and corrupt the sum.

Overflow persistence is checked across later additions and cleared by reset. Random additions are compared against a decimal model. During every operation, each digit's successive values are checked to move by zero or one stage per clock.

// File: rtl/dring_pkg.sv
// Package: shared ring constants, types and helper functions for the
// decimal ring accumulator. Assumes decimal digits (ten stages per ring).
package dring_pkg;
    localparam int RING_LEN = 10;
    localparam int BCD_W    = 4;
    localparam int MAX_STEP = RING_LEN - 1;

    typedef logic [RING_LEN-1:0] ring_t;
    typedef logic [BCD_W-1:0]    bcd_t;

    localparam ring_t RING_ZERO = ring_t'(1);

    // True when exactly one stage of the ring is active
    function automatic logic ring_legal(input ring_t r);
        return (r != '0) && ((r & (r - ring_t'(1))) == '0);
    endfunction

    // Index of the active stage, assuming the ring is legal
    function automatic bcd_t ring_to_bcd(input ring_t r);
        bcd_t v;
        v = '0;
        for (int k = 0; k < RING_LEN; k++) begin
            if (r[k]) v = bcd_t'(k);
        end
        return v;
    endfunction

    // Clamp an addend digit code to the largest legal step count
    function automatic bcd_t step_sat(input bcd_t a);
        return (a > bcd_t'(MAX_STEP)) ? bcd_t'(MAX_STEP) : a;
    endfunction
endpackage

// File: rtl/dring_digit.sv
// Module: one decimal digit held as a ten-stage one-hot ring.
// On load it takes a step count (clamped to 9) and rotates one stage per
// clock until the count is spent, then applies one queued carry step.
// Assumes at most one carry arrives per operation (10 steps wrap once).
module dring_digit
    import dring_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  bcd_t  add_i,
    input  logic  carry_i,
    output ring_t ring_o,
    output bcd_t  bcd_o,
    output logic  carry_o,
    output logic  idle_o,
    output logic  bad_o
);
    ring_t ring_q;
    bcd_t  cnt_q;
    logic  pend_q;
    logic  legal;
    logic  own_step;
    logic  carry_step;
    logic  step;

    // Decode the stepping decision for this cycle
    always_comb begin
        legal      = ring_legal(ring_q);
        own_step   = (cnt_q != '0);
        carry_step = !own_step && pend_q;
        step       = own_step || carry_step;
    end

    // Ring register: reset to zero, repair when illegal, else rotate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= RING_ZERO;
        end else if (!legal) begin
            ring_q <= RING_ZERO;
        end else if (step) begin
            ring_q <= {ring_q[RING_LEN-2:0], ring_q[RING_LEN-1]};
        end
    end

    // Own step counter: load clamped addend, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= step_sat(add_i);
        end else if (own_step) begin
            cnt_q <= cnt_q - bcd_t'(1);
        end
    end

    // Queued carry: set by the lower digit, cleared when applied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q && !carry_step) || carry_i;
        end
    end

    // Outputs: carry on a 9-to-0 step, idle when nothing is left to do
    always_comb begin
        carry_o = step && legal && ring_q[RING_LEN-1];
        idle_o  = !own_step && !pend_q;
        bad_o   = !legal;
        ring_o  = ring_q;
        bcd_o   = ring_to_bcd(ring_q);
    end
endmodule

// File: rtl/dring_seq.sv
// Module: operation sequencer and sticky flags for the ring accumulator.
// Accepts a start only when idle, holds busy until every digit reports
// idle, and keeps the overflow and illegal-ring flags until reset.
module dring_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic all_idle_i,
    input  logic top_carry_i,
    input  logic any_bad_i,
    output logic accept_o,
    output logic busy_o,
    output logic ovf_o,
    output logic err_o
);
    logic busy_q;
    logic ovf_q;
    logic err_q;

    // Accept a start only while no operation is running
    always_comb begin
        accept_o = start_i && !busy_q;
    end

    // Busy: set on an accepted start, cleared once all digits are idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
        end else if (all_idle_i) begin
            busy_q <= 1'b0;
        end
    end

    // Sticky flags: overflow out of the top digit and illegal rings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ovf_q <= ovf_q || top_carry_i;
            err_q <= err_q || any_bad_i;
        end
    end

    assign busy_o = busy_q;
    assign ovf_o  = ovf_q;
    assign err_o  = err_q;
endmodule

// File: rtl/dring_accum.sv
// Module: top of the multi-digit one-hot decimal ring accumulator.
// Instantiates one ring per digit, chains the carry pulses from digit 0
// upward, and gathers idle, overflow and error conditions for the sequencer.
module dring_accum
    import dring_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [BCD_W*NUM_DIGITS-1:0]    addend_i,
    output logic [RING_LEN*NUM_DIGITS-1:0] ring_o,
    output logic [BCD_W*NUM_DIGITS-1:0]    bcd_o,
    output logic                           busy_o,
    output logic                           ovf_o,
    output logic                           err_o
);
    localparam int ADD_W  = BCD_W * NUM_DIGITS;
    localparam int RING_W = RING_LEN * NUM_DIGITS;

    logic [NUM_DIGITS:0]   carry;
    logic [NUM_DIGITS-1:0] idle;
    logic [NUM_DIGITS-1:0] bad;
    logic                  accept;
    logic                  all_idle;
    logic                  any_bad;

    assign carry[0] = 1'b0;

    // One ring per digit, each fed by the carry of the digit below
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        dring_digit u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (accept),
            .add_i   (addend_i[BCD_W*d +: BCD_W]),
            .carry_i (carry[d]),
            .ring_o  (ring_o[RING_LEN*d +: RING_LEN]),
            .bcd_o   (bcd_o[BCD_W*d +: BCD_W]),
            .carry_o (carry[d+1]),
            .idle_o  (idle[d]),
            .bad_o   (bad[d])
        );
    end

    // Reduce per-digit status for the sequencer
    always_comb begin
        all_idle = &idle;
        any_bad  = |bad;
    end

    dring_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .all_idle_i  (all_idle),
        .top_carry_i (carry[NUM_DIGITS]),
        .any_bad_i   (any_bad),
        .accept_o    (accept),
        .busy_o      (busy_o),
        .ovf_o       (ovf_o),
        .err_o       (err_o)
    );

    if (ADD_W != BCD_W * NUM_DIGITS || RING_W != RING_LEN * NUM_DIGITS) begin : g_bad_cfg
        $error("width derivation mismatch");
    end
endmodule

// File: rtl/dring_accum_chk.sv
// Module: assertion checker for dring_accum, attached through bind.
// Assumes synchronous active-low reset; all checks are disabled in reset.
module dring_accum_chk
    import dring_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           start_i,
    input logic [RING_LEN*NUM_DIGITS-1:0] ring_o,
    input logic [BCD_W*NUM_DIGITS-1:0]    bcd_o,
    input logic                           busy_o,
    input logic                           ovf_o,
    input logic                           err_o
);
    logic [RING_LEN*NUM_DIGITS-1:0] prev_ring;
    logic                           prev_ok;

    // Track the previous ring state once a cycle out of reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ok   <= 1'b0;
            prev_ring <= '0;
        end else begin
            prev_ok   <= 1'b1;
            prev_ring <= ring_o;
        end
    end

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_chk
        AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(ring_o[RING_LEN*d +: RING_LEN])); // R2
        AST_BCD_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
            ring_o[RING_LEN*d + int'(bcd_o[BCD_W*d +: BCD_W])] == 1'b1); // R2
        AST_STEP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
            prev_ok |-> (ring_o[RING_LEN*d +: RING_LEN] == prev_ring[RING_LEN*d +: RING_LEN])
                     || (ring_o[RING_LEN*d +: RING_LEN] ==
                         {prev_ring[RING_LEN*d +: RING_LEN-1], prev_ring[RING_LEN*d + RING_LEN-1]})); // R4
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R7
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(ring_o)); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R10
endmodule

bind dring_accum dring_accum_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ring_o  (ring_o),
    .bcd_o   (bcd_o),
    .busy_o  (busy_o),
    .ovf_o   (ovf_o),
    .err_o   (err_o)
);

// File: tb/tb_dring_accum.sv
`timescale 1ns/1ps
module tb_dring_accum;
    localparam int N     = 4;
    localparam int MODV  = 10000;
    localparam int BOUND = 9 + N + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [4*N-1:0]  addend_i = '0;
    logic [10*N-1:0] ring_o;
    logic [4*N-1:0]  bcd_o;
    logic            busy_o, ovf_o, err_o;

    int errors = 0;
    int checks = 0;
    int acc_m  = 0;
    bit ovf_m  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dring_accum #(.NUM_DIGITS(N)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addend_i(addend_i),
        .ring_o(ring_o), .bcd_o(bcd_o), .busy_o(busy_o), .ovf_o(ovf_o), .err_o(err_o)
    );

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Decimal value of an addend with codes above nine clamped (R6)
    function automatic int addend_val(input logic [4*N-1:0] a);
        int v = 0;
        for (int d = N-1; d >= 0; d--) begin
            int dg = int'(a[4*d +: 4]);
            if (dg > 9) dg = 9;
            v = v*10 + dg;
        end
        return v;
    endfunction

    function automatic logic [4*N-1:0] to_bcd(input int v);
        logic [4*N-1:0] r;
        int t = v;
        for (int d = 0; d < N; d++) begin
            r[4*d +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic [10*N-1:0] to_ring(input int v);
        logic [10*N-1:0] r = '0;
        int t = v;
        for (int d = 0; d < N; d++) begin
            r[10*d + (t % 10)] = 1'b1;
            t = t / 10;
        end
        return r;
    endfunction

    function automatic int ring_val(input logic [10*N-1:0] r);
        int v = 0;
        for (int d = N-1; d >= 0; d--) begin
            int dg = 0;
            for (int k = 0; k < 10; k++) if (r[10*d+k]) dg = k;
            v = v*10 + dg;
        end
        return v;
    endfunction

    // Check the outputs against the model
    task automatic check_state(input string ctx);
        check(bcd_o == to_bcd(acc_m), {"R3 sum ", ctx}, longint'(bcd_o), longint'(to_bcd(acc_m)));
        check(ring_o == to_ring(acc_m), {"R2 ring ", ctx}, longint'(ring_o), longint'(to_ring(acc_m)));
        check(ovf_o == ovf_m, {"R9 ovf ", ctx}, longint'(ovf_o), longint'(ovf_m));
        check(err_o == 1'b0, {"R10 err ", ctx}, longint'(err_o), 0);
    endtask

    // One addition: optional second start while busy (R8)
    task automatic do_add(input logic [4*N-1:0] a, input bit extra, input logic [4*N-1:0] b, input string ctx);
        int cyc = 0;
        bit step_ok = 1;
        int prev;
        @(negedge clk);
        addend_i = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, {"R7 busy after start ", ctx}, longint'(busy_o), 1);
        if (extra) begin
            addend_i = b; start_i = 1'b1;
        end
        prev = ring_val(ring_o);
        while (busy_o && cyc < 40) begin
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
            for (int d = 0; d < N; d++) begin
                int pd = (prev / (10**d)) % 10;
                int cd = (ring_val(ring_o) / (10**d)) % 10;
                if (!(cd == pd || cd == (pd + 1) % 10)) step_ok = 0;
            end
            prev = ring_val(ring_o);
        end
        check(cyc <= BOUND, {"R7 latency ", ctx}, cyc, BOUND);
        check(step_ok, {"R4 step ", ctx}, longint'(step_ok), 1);
        if (acc_m + addend_val(a) >= MODV) ovf_m = 1;
        acc_m = (acc_m + addend_val(a)) % MODV;
        check_state(ctx);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        acc_m = 0; ovf_m = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        @(negedge clk);
        // R1: reset state
        check(ring_o == to_ring(0), "R1 ring zero", longint'(ring_o), longint'(to_ring(0)));
        check(bcd_o == '0, "R1 bcd zero", longint'(bcd_o), 0);
        check(busy_o == 0 && ovf_o == 0 && err_o == 0, "R1 flags", {busy_o, ovf_o, err_o}, 0);

        do_add(16'h0000, 0, '0, "zero addend R7");
        do_add(16'h1234, 0, '0, "plain R3");
        do_add(16'h0009, 0, '0, "single carry R5");     // 1243
        do_add(16'h8756, 0, '0, "to 9999 R3");          // 9999
        do_add(16'h0001, 0, '0, "full ripple R5 R9");   // 0000, ovf
        do_add(16'h0005, 0, '0, "ovf sticky R9");
        do_reset();
        @(negedge clk);
        check(ovf_o == 1'b0, "R9 ovf cleared by reset", longint'(ovf_o), 0);
        do_add(16'h0999, 0, '0, "pre ripple R5");
        do_add(16'h0001, 0, '0, "ripple to 1000 R5");
        do_add(16'hFAFC, 0, '0, "saturate R6");
        do_add(16'h9999, 1, 16'h1111, "start while busy R8");

        for (int i = 0; i < 40; i++) begin
            logic [4*N-1:0] a;
            for (int d = 0; d < N; d++) a[4*d +: 4] = 4'($urandom_range(0, 9));
            if (i % 8 == 7) a[3:0] = 4'($urandom_range(10, 15));
            do_add(a, (i % 5 == 0), 16'h4321, "random R3");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule